// File: doc/BRIEF.md
# E1 transmit time-slot indicator

This block follows the bit position inside the outgoing E1 bit stream and tells the terminal equipment which 64 kbit/s channel it is handing over at that moment. It runs on the bit-rate clock. It keeps a bit-in-slot counter, a slot-in-frame counter and a frame-in-multiframe counter. From these it drives a binary channel number on a small group of pins and a strobe once per slot.

The frame and multiframe syncs come from one of two places, chosen by a timing-source selector. With either internal source (divided oscillator or recovered receive clock), the block drives the syncs and raises an output enable for the clock and sync pins. With the external source, those pins become inputs, and each incoming sync realigns the counters.

A single control bit turns the number pins into a fractional-E1 port. In that mode two of the pins take in payload and signaling data, which pass straight through. One pin shifts out the channel number serially. One pin marks the start of each multiframe. The strobe becomes either a gapped clock or a clock enable, active only in the channels that a 32-bit mask selects.

Top module: `e1_tx_slot_indicator`

## Requirements
- R1: While reset is held, and in the first bit period after it, the position is bit 0 of slot 0 of frame 0. With the default configuration (normal mode, an internal timing source) this gives `ts_pin_out` = 0, `ts_strobe` = 0, `frame_sync_out` = 1 and `mfrm_sync_out` = 1.
- R2: In normal mode (`cfg_frac_en` = 0), `ts_pin_out` carries the current slot number 0..31 in binary, with bit 4 as the MSB. The number advances every 8 bit periods and wraps from 31 to 0.
- R3: In normal mode, `ts_strobe` is high for exactly one bit period per slot: bit 7, the last and least significant bit, since bits are sent MSB first.
- R4: With `cfg_tmg_src` at 1 (oscillator) or 2 (recovered), `tmg_sync_oe` is 1. `frame_sync_out` is high during bit 0 of slot 0. `mfrm_sync_out` is high during bit 0 of slot 0 of frame 0.
- R5: With `cfg_tmg_src` = 0 (external), `tmg_sync_oe`, `frame_sync_out` and `mfrm_sync_out` are 0. A high `frame_sync_in` makes that bit period bit 0 of slot 0. A high `mfrm_sync_in` makes that bit period part of frame 0. The counters then run on from that point.
- R6: In fractional mode (`cfg_frac_en` = 1), `ts_pin_oe` = 5'b11100, so pins 0 and 1 are inputs. `frac_data_out` follows `ts_pin_in[0]` and `sig_data_out` follows `ts_pin_in[1]`. In normal mode `ts_pin_oe` = 5'b11111 and both pass-through outputs are 0.
- R7: In fractional mode, `ts_pin_out[2]` presents the current slot number MSB first: bit k of the slot (k = 0..4) shows number bit 4-k. During bits 5 to 7 the pin is 0.
- R8: In fractional mode, `ts_pin_out[3]` is high only during bit 0 of slot 0 of frame 0. `ts_pin_out[4]`, `ts_pin_out[1]` and `ts_pin_out[0]` are 0.
- R9: In fractional mode with `cfg_strobe_mode` = 1 (clock enable), `ts_strobe` equals `cfg_slot_mask[slot]` for all 8 bit periods of each slot.
- R10: In fractional mode with `cfg_strobe_mode` = 0 (gapped clock), `ts_strobe` is `cfg_slot_mask[slot]` during the low half of each clock period and 0 during the high half. Its rising edges therefore fall mid-bit, only in selected slots.
- R11: The frame counter counts 16 frames of 256 bits each and then wraps to 0, so with internal timing `mfrm_sync_out` repeats every 4096 bit periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_frac_en | input | 1 | 0 selects normal mode, 1 selects fractional mode |
| cfg_strobe_mode | input | 1 | In fractional mode: 0 selects the gapped clock, 1 selects the clock enable |
| cfg_tmg_src | input | 2 | 0 external, 1 oscillator, 2 recovered, 3 treated as internal |
| cfg_slot_mask | input | 32 | Bit n set selects slot n for fractional payload |
| frame_sync_in | input | 1 | External frame sync, high during bit 0 of slot 0 |
| mfrm_sync_in | input | 1 | External multiframe sync, high during a bit of frame 0 |
| ts_pin_in | input | 2 | Input side of number pins 0 and 1 |
| ts_pin_out | output | 5 | Output side of the number pins |
| ts_pin_oe | output | 5 | Per-pin output enable for the number pins |
| frame_sync_out | output | 1 | Generated frame sync |
| mfrm_sync_out | output | 1 | Generated multiframe sync |
| tmg_sync_oe | output | 1 | Output enable for the serial clock and the sync pins |
| ts_strobe | output | 1 | Slot strobe, gapped clock or clock enable |
| frac_data_out | output | 1 | Fractional payload data taken from pin 0 |
| sig_data_out | output | 1 | Signaling data taken from pin 1 |

## Verification
Every output is a combinational function of the registered position and the present inputs. Each result therefore belongs to the same bit period as its stimulus, and an incoming sync changes the outputs within that bit period. The counters move only at the next rising edge, so the reference model in the bench advances at that edge. The bench changes inputs 1 ns after a rising edge and compares every output 6 ns after it, in the low half of the period. It also samples the strobe 2 ns after the edge, in the high half, so that the gapped clock is seen in both of its halves.

// File: rtl/e1_tsi_pkg.sv
package e1_tsi_pkg;

   typedef enum logic [1:0] {
      TSRC_EXT = 2'd0,
      TSRC_OSC = 2'd1,
      TSRC_REC = 2'd2,
      TSRC_RSV = 2'd3
   } tmg_src_e;

   // Pin roles while the fractional port is enabled; a neighbour decodes these positions
   localparam int PIN_DATA = 0;
   localparam int PIN_SIG  = 1;
   localparam int PIN_SER  = 2;
   localparam int PIN_OHS  = 3;
   localparam int PIN_MIN  = 4;

   localparam logic STB_GAPPED = 1'b0;
   localparam logic STB_ENABLE = 1'b1;

endpackage

// File: rtl/e1_tsi_pos_counter.sv
module e1_tsi_pos_counter #(
   parameter int BITS_PER_SLOT   = 8,
   parameter int SLOTS_PER_FRAME = 32,
   parameter int FRAMES_PER_MF   = 16,
   localparam int BIT_W   = $clog2(BITS_PER_SLOT),
   localparam int SLOT_W  = $clog2(SLOTS_PER_FRAME),
   localparam int FRAME_W = $clog2(FRAMES_PER_MF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ext_mode,
   input  logic               fs_in,
   input  logic               ms_in,
   output logic [BIT_W-1:0]   bit_idx,
   output logic [SLOT_W-1:0]  slot_idx,
   output logic [FRAME_W-1:0] frame_idx
);

   localparam logic [BIT_W-1:0]   BIT_LAST   = BIT_W'(BITS_PER_SLOT - 1);
   localparam logic [SLOT_W-1:0]  SLOT_LAST  = SLOT_W'(SLOTS_PER_FRAME - 1);
   localparam logic [FRAME_W-1:0] FRAME_LAST = FRAME_W'(FRAMES_PER_MF - 1);

   logic [BIT_W-1:0]   bit_q;
   logic [SLOT_W-1:0]  slot_q;
   logic [FRAME_W-1:0] frame_q;
   logic               fs_hit;
   logic               ms_hit;
   logic               bit_wrap;
   logic               slot_wrap;

   // An incoming sync takes effect within the bit period it occupies
   assign fs_hit = ext_mode & fs_in;
   assign ms_hit = ext_mode & ms_in;

   always_comb begin
      bit_idx   = fs_hit ? '0 : bit_q;
      slot_idx  = fs_hit ? '0 : slot_q;
      frame_idx = ms_hit ? '0 : frame_q;
   end

   assign bit_wrap  = (bit_idx == BIT_LAST);
   assign slot_wrap = bit_wrap & (slot_idx == SLOT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q   <= '0;
         slot_q  <= '0;
         frame_q <= '0;
      end else begin
         bit_q <= bit_wrap ? '0 : bit_idx + 1'b1;
         if (bit_wrap) begin
            slot_q <= (slot_idx == SLOT_LAST) ? '0 : slot_idx + 1'b1;
         end else begin
            slot_q <= slot_idx;
         end
         if (slot_wrap) begin
            frame_q <= (frame_idx == FRAME_LAST) ? '0 : frame_idx + 1'b1;
         end else begin
            frame_q <= frame_idx;
         end
      end
   end

endmodule

// File: rtl/e1_tsi_sync_gen.sv
module e1_tsi_sync_gen #(
   parameter int BIT_W   = 3,
   parameter int SLOT_W  = 5,
   parameter int FRAME_W = 4
) (
   input  logic               ext_mode,
   input  logic [BIT_W-1:0]   bit_idx,
   input  logic [SLOT_W-1:0]  slot_idx,
   input  logic [FRAME_W-1:0] frame_idx,
   output logic               frame_start,
   output logic               mf_start,
   output logic               frame_sync_out,
   output logic               mfrm_sync_out,
   output logic               tmg_sync_oe
);

   assign frame_start = (bit_idx == '0) & (slot_idx == '0);
   assign mf_start    = frame_start & (frame_idx == '0);

   // The clock and sync pins point outward only for the internal sources
   assign tmg_sync_oe    = ~ext_mode;
   assign frame_sync_out = tmg_sync_oe & frame_start;
   assign mfrm_sync_out  = tmg_sync_oe & mf_start;

endmodule

// File: rtl/e1_tsi_pin_mux.sv
module e1_tsi_pin_mux
   import e1_tsi_pkg::*;
#(
   parameter int TSN_W = 5,
   parameter int BIT_W = 3
) (
   input  logic             frac_en,
   input  logic [BIT_W-1:0] bit_idx,
   input  logic [TSN_W-1:0] slot_idx,
   input  logic             mf_start,
   input  logic [1:0]       pin_in,
   output logic [TSN_W-1:0] pin_out,
   output logic [TSN_W-1:0] pin_oe,
   output logic             frac_data,
   output logic             sig_data
);

   logic ser_bit;

   // Serial number: MSB in bit 0 of the slot, zero after the last number bit
   always_comb begin
      ser_bit = 1'b0;
      for (int k = 0; k < TSN_W; k++) begin
         if (int'(bit_idx) == k) begin
            ser_bit = slot_idx[TSN_W-1-k];
         end
      end
   end

   for (genvar p = 0; p < TSN_W; p++) begin : g_pin
      if (p == PIN_DATA || p == PIN_SIG) begin : g_in
         assign pin_out[p] = frac_en ? 1'b0 : slot_idx[p];
         assign pin_oe[p]  = ~frac_en;
      end else if (p == PIN_SER) begin : g_ser
         assign pin_out[p] = frac_en ? ser_bit : slot_idx[p];
         assign pin_oe[p]  = 1'b1;
      end else if (p == PIN_OHS) begin : g_ohs
         assign pin_out[p] = frac_en ? mf_start : slot_idx[p];
         assign pin_oe[p]  = 1'b1;
      end else begin : g_spare
         assign pin_out[p] = frac_en ? 1'b0 : slot_idx[p];
         assign pin_oe[p]  = 1'b1;
      end
   end

   assign frac_data = frac_en & pin_in[PIN_DATA];
   assign sig_data  = frac_en & pin_in[PIN_SIG];

endmodule

// File: rtl/e1_tsi_strobe_gen.sv
module e1_tsi_strobe_gen
   import e1_tsi_pkg::*;
#(
   parameter int BITS_PER_SLOT   = 8,
   parameter int SLOTS_PER_FRAME = 32,
   localparam int BIT_W  = $clog2(BITS_PER_SLOT),
   localparam int SLOT_W = $clog2(SLOTS_PER_FRAME)
) (
   input  logic                       clk,
   input  logic                       frac_en,
   input  logic                       strobe_mode,
   input  logic [BIT_W-1:0]           bit_idx,
   input  logic [SLOT_W-1:0]          slot_idx,
   input  logic [SLOTS_PER_FRAME-1:0] slot_mask,
   output logic                       strobe
);

   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS_PER_SLOT - 1);

   logic sel;
   logic lsb;

   assign sel = slot_mask[slot_idx];
   assign lsb = (bit_idx == BIT_LAST);

   // The gapped clock rises mid-bit; the selection changes only while clk is high
   always_comb begin
      if (!frac_en) begin
         strobe = lsb;
      end else if (strobe_mode == STB_ENABLE) begin
         strobe = sel;
      end else begin
         strobe = sel & ~clk;
      end
   end

endmodule

// File: rtl/e1_tx_slot_indicator.sv
module e1_tx_slot_indicator
   import e1_tsi_pkg::*;
#(
   parameter int BITS_PER_SLOT   = 8,
   parameter int SLOTS_PER_FRAME = 32,
   parameter int FRAMES_PER_MF   = 16,
   localparam int TSN_W   = $clog2(SLOTS_PER_FRAME),
   localparam int BIT_W   = $clog2(BITS_PER_SLOT),
   localparam int FRAME_W = $clog2(FRAMES_PER_MF)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_frac_en,
   input  logic                       cfg_strobe_mode,
   input  logic [1:0]                 cfg_tmg_src,
   input  logic [SLOTS_PER_FRAME-1:0] cfg_slot_mask,
   input  logic                       frame_sync_in,
   input  logic                       mfrm_sync_in,
   input  logic [1:0]                 ts_pin_in,
   output logic [TSN_W-1:0]           ts_pin_out,
   output logic [TSN_W-1:0]           ts_pin_oe,
   output logic                       frame_sync_out,
   output logic                       mfrm_sync_out,
   output logic                       tmg_sync_oe,
   output logic                       ts_strobe,
   output logic                       frac_data_out,
   output logic                       sig_data_out
);

   if (SLOTS_PER_FRAME != (1 << TSN_W)) begin : g_bad_slots
      $error("SLOTS_PER_FRAME must be a power of two");
   end
   if (BITS_PER_SLOT != (1 << BIT_W) || BITS_PER_SLOT < TSN_W) begin : g_bad_bits
      $error("BITS_PER_SLOT must be a power of two that holds the serial number");
   end
   if (TSN_W < PIN_MIN) begin : g_bad_pins
      $error("the fractional port needs at least four number pins");
   end
   if (FRAMES_PER_MF < 2 || FRAMES_PER_MF != (1 << FRAME_W)) begin : g_bad_frames
      $error("FRAMES_PER_MF must be a power of two of at least 2");
   end

   logic               ext_mode;
   logic [BIT_W-1:0]   bit_idx;
   logic [TSN_W-1:0]   slot_idx;
   logic [FRAME_W-1:0] frame_idx;
   logic               frame_start;
   logic               mf_start;

   assign ext_mode = (tmg_src_e'(cfg_tmg_src) == TSRC_EXT);

   e1_tsi_pos_counter #(
      .BITS_PER_SLOT  (BITS_PER_SLOT),
      .SLOTS_PER_FRAME(SLOTS_PER_FRAME),
      .FRAMES_PER_MF  (FRAMES_PER_MF)
   ) u_pos (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_mode (ext_mode),
      .fs_in    (frame_sync_in),
      .ms_in    (mfrm_sync_in),
      .bit_idx  (bit_idx),
      .slot_idx (slot_idx),
      .frame_idx(frame_idx)
   );

   e1_tsi_sync_gen #(
      .BIT_W  (BIT_W),
      .SLOT_W (TSN_W),
      .FRAME_W(FRAME_W)
   ) u_sync (
      .ext_mode      (ext_mode),
      .bit_idx       (bit_idx),
      .slot_idx      (slot_idx),
      .frame_idx     (frame_idx),
      .frame_start   (frame_start),
      .mf_start      (mf_start),
      .frame_sync_out(frame_sync_out),
      .mfrm_sync_out (mfrm_sync_out),
      .tmg_sync_oe   (tmg_sync_oe)
   );

   e1_tsi_pin_mux #(
      .TSN_W(TSN_W),
      .BIT_W(BIT_W)
   ) u_pins (
      .frac_en  (cfg_frac_en),
      .bit_idx  (bit_idx),
      .slot_idx (slot_idx),
      .mf_start (mf_start),
      .pin_in   (ts_pin_in),
      .pin_out  (ts_pin_out),
      .pin_oe   (ts_pin_oe),
      .frac_data(frac_data_out),
      .sig_data (sig_data_out)
   );

   e1_tsi_strobe_gen #(
      .BITS_PER_SLOT  (BITS_PER_SLOT),
      .SLOTS_PER_FRAME(SLOTS_PER_FRAME)
   ) u_stb (
      .clk        (clk),
      .frac_en    (cfg_frac_en),
      .strobe_mode(cfg_strobe_mode),
      .bit_idx    (bit_idx),
      .slot_idx   (slot_idx),
      .slot_mask  (cfg_slot_mask),
      .strobe     (ts_strobe)
   );

endmodule

// File: rtl/e1_tsi_chk.sv
module e1_tsi_chk #(
   parameter int SLOTS_PER_FRAME = 32,
   localparam int TSN_W = $clog2(SLOTS_PER_FRAME)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_frac_en,
   input logic [1:0]       cfg_tmg_src,
   input logic             frame_sync_in,
   input logic [TSN_W-1:0] ts_pin_out,
   input logic [TSN_W-1:0] ts_pin_oe,
   input logic             frame_sync_out,
   input logic             mfrm_sync_out,
   input logic             tmg_sync_oe,
   input logic             ts_strobe
);

   assert_lsb_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_frac_en && ts_strobe) |=> (cfg_frac_en || !ts_strobe));

   assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_frac_en && ts_strobe && cfg_tmg_src != 2'd0)
      |=> (cfg_frac_en || cfg_tmg_src == 2'd0 || ts_pin_out == $past(ts_pin_out) + 1'b1));

   assert_int_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_tmg_src != 2'd0) |-> tmg_sync_oe);

   assert_mf_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mfrm_sync_out |-> frame_sync_out);

   assert_ext_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_tmg_src == 2'd0) |-> (!tmg_sync_oe && !frame_sync_out && !mfrm_sync_out));

   assert_ext_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_tmg_src == 2'd0 && frame_sync_in && !cfg_frac_en) |-> (ts_pin_out == '0));

   assert_frac_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_frac_en |-> (ts_pin_oe[1:0] == 2'b00 && (&ts_pin_oe[TSN_W-1:2])));

endmodule

bind e1_tx_slot_indicator e1_tsi_chk #(
   .SLOTS_PER_FRAME(SLOTS_PER_FRAME)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_frac_en   (cfg_frac_en),
   .cfg_tmg_src   (cfg_tmg_src),
   .frame_sync_in (frame_sync_in),
   .ts_pin_out    (ts_pin_out),
   .ts_pin_oe     (ts_pin_oe),
   .frame_sync_out(frame_sync_out),
   .mfrm_sync_out (mfrm_sync_out),
   .tmg_sync_oe   (tmg_sync_oe),
   .ts_strobe     (ts_strobe)
);

// File: tb/sim_e1_tx_slot_indicator.sv
`timescale 1ns/1ps
module sim_e1_tx_slot_indicator;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_frac_en;
   logic        cfg_strobe_mode;
   logic [1:0]  cfg_tmg_src;
   logic [31:0] cfg_slot_mask;
   logic        frame_sync_in;
   logic        mfrm_sync_in;
   logic [1:0]  ts_pin_in;
   logic [4:0]  ts_pin_out;
   logic [4:0]  ts_pin_oe;
   logic        frame_sync_out;
   logic        mfrm_sync_out;
   logic        tmg_sync_oe;
   logic        ts_strobe;
   logic        frac_data_out;
   logic        sig_data_out;

   always #4 clk = ~clk;

   e1_tx_slot_indicator u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_frac_en    (cfg_frac_en),
      .cfg_strobe_mode(cfg_strobe_mode),
      .cfg_tmg_src    (cfg_tmg_src),
      .cfg_slot_mask  (cfg_slot_mask),
      .frame_sync_in  (frame_sync_in),
      .mfrm_sync_in   (mfrm_sync_in),
      .ts_pin_in      (ts_pin_in),
      .ts_pin_out     (ts_pin_out),
      .ts_pin_oe      (ts_pin_oe),
      .frame_sync_out (frame_sync_out),
      .mfrm_sync_out  (mfrm_sync_out),
      .tmg_sync_oe    (tmg_sync_oe),
      .ts_strobe      (ts_strobe),
      .frac_data_out  (frac_data_out),
      .sig_data_out   (sig_data_out)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   // Behavioural position model: bit, slot, frame
   int m_b = 0, m_s = 0, m_f = 0;
   int p_b = 0, p_s = 0, p_f = 0;

   logic        nx_rst_n = 1'b0;
   logic        nx_frac  = 1'b0;
   logic        nx_mode  = 1'b1;
   logic [1:0]  nx_src   = 2'd1;
   logic [31:0] nx_mask  = 32'hA5F0_0C31;
   logic        nx_fs    = 1'b0;
   logic        nx_ms    = 1'b0;

   initial begin
      rst_n = 1'b0; cfg_frac_en = 1'b0; cfg_strobe_mode = 1'b1; cfg_tmg_src = 2'd1;
      cfg_slot_mask = 32'hA5F0_0C31; frame_sync_in = 1'b0; mfrm_sync_in = 1'b0; ts_pin_in = 2'b00;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
      end
   endtask

   task automatic step();
      bit ext, mf, fs0, ser;
      logic [4:0] exp_pins;
      @(posedge clk);
      if (rst_n) begin
         m_b = p_b + 1; m_s = p_s; m_f = p_f;
         if (m_b == 8) begin
            m_b = 0; m_s++;
            if (m_s == 32) begin m_s = 0; m_f = (m_f + 1) % 16; end
         end
      end else begin
         m_b = 0; m_s = 0; m_f = 0;
      end
      #1;
      rst_n = nx_rst_n; cfg_frac_en = nx_frac; cfg_strobe_mode = nx_mode;
      cfg_tmg_src = nx_src; cfg_slot_mask = nx_mask;
      frame_sync_in = nx_fs; mfrm_sync_in = nx_ms;
      ts_pin_in = 2'((cyc * 5) ^ (cyc >> 2));
      cyc++;
      ext = (nx_src == 2'd0);
      p_b = m_b; p_s = m_s; p_f = m_f;
      if (ext && nx_fs) begin p_b = 0; p_s = 0; end
      if (ext && nx_ms) p_f = 0;
      fs0 = (p_b == 0 && p_s == 0);
      mf  = fs0 && (p_f == 0);
      ser = (p_b < 5) ? 1'((p_s >> (4 - p_b)) & 1) : 1'b0;
      #1;
      // High half of the period
      if (!nx_frac)      chk("R3", 32'(ts_strobe), 32'(p_b == 7));
      else if (nx_mode)  chk("R9", 32'(ts_strobe), 32'(nx_mask[p_s]));
      else               chk("R10", 32'(ts_strobe), 32'd0);
      #4;
      // Low half of the period
      exp_pins = nx_frac ? {1'b0, mf, ser, 2'b00} : 5'(p_s);
      chk(nx_frac ? "R7 R8" : (ext ? "R5" : "R2"), 32'(ts_pin_out), 32'(exp_pins));
      chk("R6", 32'(ts_pin_oe), nx_frac ? 32'h1C : 32'h1F);
      chk("R6", 32'({frac_data_out, sig_data_out}),
          nx_frac ? 32'({ts_pin_in[0], ts_pin_in[1]}) : 32'd0);
      if (!nx_frac)      chk("R3", 32'(ts_strobe), 32'(p_b == 7));
      else if (nx_mode)  chk("R9", 32'(ts_strobe), 32'(nx_mask[p_s]));
      else               chk("R10", 32'(ts_strobe), 32'(nx_mask[p_s]));
      chk(ext ? "R5" : "R4", 32'(frame_sync_out), 32'(!ext && fs0));
      chk(ext ? "R5" : "R11", 32'(mfrm_sync_out), 32'(!ext && mf));
      chk(ext ? "R5" : "R4", 32'(tmg_sync_oe), 32'(!ext));
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      // R1: reset state at the ports
      chk("R1", 32'(ts_pin_out), 32'd0);
      chk("R1", 32'(ts_strobe), 32'd0);
      chk("R1", 32'({frame_sync_out, mfrm_sync_out}), 32'd3);
      nx_rst_n = 1'b1;
      step();
      chk("R1", 32'(ts_pin_out), 32'd0);
      // Normal mode, oscillator timing, past the multiframe wrap (R11)
      repeat (4200) step();
      // Fractional, recovered timing, clock-enable strobe
      nx_src = 2'd2; nx_frac = 1'b1; nx_mode = 1'b1;
      repeat (600) step();
      // Gapped clock with selection around the frame wrap
      nx_mode = 1'b0; nx_mask = 32'h8000_0003;
      repeat (600) step();
      // External timing: realign mid-slot, then regular syncs
      nx_src = 2'd0; nx_frac = 1'b0;
      repeat (101) step();
      nx_fs = 1'b1; step(); nx_fs = 1'b0;
      repeat (150) step();
      nx_ms = 1'b1; step(); nx_ms = 1'b0;
      for (int k = 0; k < 3; k++) begin
         repeat (255) step();
         nx_fs = 1'b1; nx_ms = (k == 1); step();
         nx_fs = 1'b0; nx_ms = 1'b0;
      end
      // External timing with the fractional port
      nx_frac = 1'b1; nx_mode = 1'b1; nx_mask = 32'h0F0F_1234;
      repeat (77) step();
      nx_fs = 1'b1; nx_ms = 1'b1; step(); nx_fs = 1'b0; nx_ms = 1'b0;
      repeat (400) step();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule